// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block watches eight already-synchronized GPIO pin values and raises per-pin interrupt status according to a per-pin configuration. Each pin is configured for level sensing or edge sensing. In edge mode a pin either reacts to any change or to one polarity only. The same polarity bit also picks the active level in level mode. The configuration masks are driven by register storage that lives outside the block.

Every cycle the detector compares the present pin values with a registered copy of the previous ones. It sets sticky raw status bits, clears them through a write-one-to-clear vector, and produces a masked status and one combined interrupt line. Internally a control module turns pins and configuration into a struct of set and clear strobes. A datapath module owns the previous-value register and the status register.

Top module: `gpio_irq_detect`

## Requirements
- R1: While `rstN` is low, and on the first cycle after reset, `rawStatus`, `maskedStatus` and `irqOut` are all zero and the previous-value copy is all zeros.
- R2: Edge detection only applies to pins whose `dirMask` bit is 0 (input). A pin with `dirMask` bit 1 never gets its status set by a change of its value.
- R3: A pin with `senseMask` bit 0 and `bothMask` bit 1 sets its raw status bit on the clock edge after any change of its value, rising or falling.
- R4: A pin with `senseMask` bit 0 and `bothMask` bit 0 sets its status only on a change whose new value equals its `eventMask` bit: 1 means rising, 0 means falling.
- R5: A pin with `senseMask` bit 1 sets its status on every clock edge where its value equals its `eventMask` bit, whatever its direction. A change to the other value sets nothing.
- R6: `maskedStatus` equals `rawStatus` AND `enableMask`, and `irqOut` is 1 exactly when `maskedStatus` is nonzero. Both are combinational from the status register and `enableMask`.
- R7: A 1 in `clearVec` during a cycle clears that raw status bit at the next clock edge. Bits whose `clearVec` bit is 0 are not cleared.
- R8: When a clear and a new detection hit the same bit in one cycle, the bit ends up set. An active level re-sets a cleared bit every cycle.
- R9: With no detection and no clear, every raw status bit holds its value.
- R10: The previous-value copy updates every cycle and starts at zero. An input pin already high when reset is released counts as a rising change on the first clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pinIn | input | 8 | Synchronized pin values |
| dirMask | input | 8 | 1 = output pin, 0 = input pin |
| senseMask | input | 8 | 1 = level sensing, 0 = edge sensing |
| bothMask | input | 8 | In edge mode, 1 = react to either edge |
| eventMask | input | 8 | Polarity: 1 = rising or high, 0 = falling or low |
| enableMask | input | 8 | Per-pin enable toward the combined interrupt |
| clearVec | input | 8 | Write-one-to-clear strobe for raw status |
| rawStatus | output | 8 | Sticky raw status |
| maskedStatus | output | 8 | Raw status AND enable |
| irqOut | output | 1 | OR of the masked status bits |

## Verification
The bench goes after a clear that coincides with a detection on the same bit. A design that gives the clear priority would lose that event, or would drop a still-active level for one cycle. It toggles output pins in edge mode, where a design that ignores direction would raise spurious status. It changes a level-mode pin to its inactive value, where a design that leaks edge logic into level mode would set status. It releases reset with a pin already high; a wrong reset value of the previous copy would miss that rising change or invent one. A long pseudo-random sweep over pins, configurations and clears compares against an arithmetic model on every cycle, to catch swapped polarities and missing stickiness.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;
  localparam int PIN_COUNT = 8;
  typedef logic [PIN_COUNT-1:0] pinVec_t;
  // strobes from the detection control into the status datapath
  typedef struct packed {
    pinVec_t setHit;
    pinVec_t clrHit;
  } irqStrobe_t;
endpackage

// File: rtl/gpio_irq_ctrl.sv
`timescale 1ns/1ps
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  pinVec_t    pinIn,
  input  pinVec_t    prevIn,
  input  pinVec_t    dirMask,
  input  pinVec_t    senseMask,
  input  pinVec_t    bothMask,
  input  pinVec_t    eventMask,
  input  pinVec_t    clearVec,
  output irqStrobe_t strobe
);
  pinVec_t changed;
  pinVec_t setVec;

  // only input pins can produce a change event
  assign changed = (prevIn ^ pinIn) & ~dirMask;

  for (genvar i = 0; i < PIN_COUNT; i++) begin : g_pin
    logic matchLvl;
    assign matchLvl = (pinIn[i] == eventMask[i]);
    assign setVec[i] = senseMask[i] ? matchLvl
                     : (bothMask[i] ? changed[i] : (changed[i] & matchLvl));
  end

  assign strobe.setHit = setVec;
  assign strobe.clrHit = clearVec;

  // output pins in edge mode never request a set
  assert_no_out_edge_R2: assert property (@(posedge clk) disable iff (!rstN)
    ((strobe.setHit & dirMask & ~senseMask) == '0));

  // an active level always requests a set
  assert_level_set_R5: assert property (@(posedge clk) disable iff (!rstN)
    ((senseMask & ~(pinIn ^ eventMask) & ~strobe.setHit) == '0));

  // a steady pin in edge mode requests nothing
  assert_steady_edge_R4: assert property (@(posedge clk) disable iff (!rstN)
    ((strobe.setHit & ~senseMask & ~(pinIn ^ prevIn)) == '0));
endmodule

// File: rtl/gpio_irq_dp.sv
`timescale 1ns/1ps
module gpio_irq_dp
  import gpio_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  pinVec_t    pinIn,
  input  pinVec_t    enableMask,
  input  irqStrobe_t strobe,
  output pinVec_t    prevIn,
  output pinVec_t    rawStatus,
  output pinVec_t    maskedStatus,
  output logic       irqOut
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevIn    <= '0;
      rawStatus <= '0;
    end else begin
      prevIn    <= pinIn;
      rawStatus <= (rawStatus & ~strobe.clrHit) | strobe.setHit;
    end
  end

  assign maskedStatus = rawStatus & enableMask;
  assign irqOut       = |maskedStatus;

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    ((strobe.setHit == '0) && (strobe.clrHit == '0)) |=> (rawStatus == $past(rawStatus)));

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((rawStatus & $past(strobe.clrHit & ~strobe.setHit)) == '0));

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((rawStatus & $past(strobe.setHit)) == $past(strobe.setHit)));
endmodule

// File: rtl/gpio_irq_detect.sv
`timescale 1ns/1ps
module gpio_irq_detect
  import gpio_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] pinIn,
  input  logic [7:0] dirMask,
  input  logic [7:0] senseMask,
  input  logic [7:0] bothMask,
  input  logic [7:0] eventMask,
  input  logic [7:0] enableMask,
  input  logic [7:0] clearVec,
  output logic [7:0] rawStatus,
  output logic [7:0] maskedStatus,
  output logic       irqOut
);
  irqStrobe_t strobe;
  pinVec_t    prevIn;

  gpio_irq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .prevIn(prevIn),
    .dirMask(dirMask), .senseMask(senseMask), .bothMask(bothMask),
    .eventMask(eventMask), .clearVec(clearVec), .strobe(strobe)
  );

  gpio_irq_dp u_dp (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .enableMask(enableMask),
    .strobe(strobe), .prevIn(prevIn), .rawStatus(rawStatus),
    .maskedStatus(maskedStatus), .irqOut(irqOut)
  );

  assert_disabled_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    (enableMask == '0) |-> (!irqOut && maskedStatus == '0));

  assert_first_cycle_R1: assert property (@(posedge clk)
    !rstN |=> (rawStatus == '0));
endmodule

// File: tb/gpio_irq_detect_bench.sv
`timescale 1ns/1ps
module gpio_irq_detect_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] pinIn = '0, dirMask = '0, senseMask = '0, bothMask = '0;
  logic [7:0] eventMask = '0, enableMask = '0, clearVec = '0;
  logic [7:0] rawStatus, maskedStatus;
  logic irqOut;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [7:0] mPrev = '0, mStat = '0;

  always #10 clk = ~clk;  // 50 MHz

  gpio_irq_detect u_gpio_irq_detect (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .dirMask(dirMask),
    .senseMask(senseMask), .bothMask(bothMask), .eventMask(eventMask),
    .enableMask(enableMask), .clearVec(clearVec), .rawStatus(rawStatus),
    .maskedStatus(maskedStatus), .irqOut(irqOut)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] modelSet(logic [7:0] p, logic [7:0] pv,
      logic [7:0] d, logic [7:0] s, logic [7:0] b, logic [7:0] e);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) begin
      logic chg;
      chg = (p[i] != pv[i]) && !d[i];
      if (s[i]) r[i] = (p[i] == e[i]);
      else if (b[i]) r[i] = chg;
      else r[i] = chg && (p[i] == e[i]);
    end
    return r;
  endfunction

  // drive at the falling edge, let one rising edge pass, compare 5 ns later
  task automatic step(string tag, logic [7:0] p, logic [7:0] d, logic [7:0] s,
      logic [7:0] b, logic [7:0] e, logic [7:0] en, logic [7:0] clr);
    @(negedge clk);
    pinIn = p; dirMask = d; senseMask = s; bothMask = b;
    eventMask = e; enableMask = en; clearVec = clr;
    mStat = (mStat & ~clr) | modelSet(p, mPrev, d, s, b, e);
    mPrev = p;
    @(posedge clk);
    #5;
    check({tag, " raw"}, rawStatus, mStat);
    check({tag, " masked"}, maskedStatus, mStat & en);
    check({tag, " irq"}, {7'b0, irqOut}, {7'b0, |(mStat & en)});
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsrA;
    logic [15:0] lfsrB;
    lfsrA = 16'hACE1;
    lfsrB = 16'h1D2F;
    // R1: reset state, pin already high with both-edges on bit 0
    pinIn = 8'h01; bothMask = 8'h01; enableMask = 8'hFF;
    repeat (3) @(posedge clk);
    #5;
    check("R1 raw in reset", rawStatus, 8'h00);
    check("R1 irq in reset", {7'b0, irqOut}, 8'h00);
    // R10: release reset, previous copy is zero so bit 0 is a rising change
    @(negedge clk);
    rstN = 1'b1;
    mStat = 8'h01; mPrev = 8'h01;
    @(posedge clk);
    #5;
    check("R10 first edge", rawStatus, 8'h01);

    // R7: clear everything
    step("R7 clear all", 8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 8'hFF);
    check("R7 literal", rawStatus, 8'h00);
    // R3: either edge on bit 1
    step("R3 rise", 8'h03, 8'h00, 8'h00, 8'h02, 8'h00, 8'hFF, 8'h00);
    check("R3 rise literal", rawStatus, 8'h02);
    // R8: falling change on bit 1 together with a clear of bit 1
    step("R8 set beats clear", 8'h01, 8'h00, 8'h00, 8'h02, 8'h00, 8'hFF, 8'h02);
    check("R8 literal", rawStatus, 8'h02);
    step("R7 clear bit1", 8'h01, 8'h00, 8'h00, 8'h02, 8'h00, 8'hFF, 8'h02);
    check("R7 clear literal", rawStatus, 8'h00);
    // R4: falling-only, a rising change is ignored
    step("R4 rise ignored", 8'h03, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 8'h00);
    check("R4 rise ignored literal", rawStatus, 8'h00);
    step("R4 fall seen", 8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 8'h00);
    check("R4 fall literal", rawStatus, 8'h02);
    step("R9 hold", 8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 8'h00);
    check("R9 sticky literal", rawStatus, 8'h02);
    step("R4 rising select", 8'h03, 8'h00, 8'h00, 8'h00, 8'h02, 8'hFF, 8'h02);
    check("R4 rising literal", rawStatus, 8'h02);
    step("R7 clr", 8'h03, 8'h00, 8'h00, 8'h00, 8'h02, 8'hFF, 8'hFF);
    // R2: output pin bit 2 toggles in both-edges mode
    step("R2 output toggle", 8'h07, 8'h04, 8'h00, 8'h04, 8'h00, 8'hFF, 8'h00);
    check("R2 literal", rawStatus, 8'h00);
    step("R2 output toggle back", 8'h03, 8'h04, 8'h00, 8'h04, 8'h00, 8'hFF, 8'h00);
    check("R2 literal 2", rawStatus, 8'h00);
    // R5: level low on bit 3, pin configured as output
    step("R5 level low", 8'h03, 8'h08, 8'h08, 8'h00, 8'h00, 8'hFF, 8'h00);
    check("R5 literal", rawStatus, 8'h08);
    step("R8 level reasserts", 8'h03, 8'h08, 8'h08, 8'h00, 8'h00, 8'hFF, 8'h08);
    check("R8 level literal", rawStatus, 8'h08);
    step("R5 inactive clear", 8'h0B, 8'h08, 8'h08, 8'h00, 8'h00, 8'hFF, 8'h08);
    check("R5 change to inactive sets nothing", rawStatus, 8'h00);
    step("R5 stay inactive", 8'h0B, 8'h00, 8'h08, 8'h00, 8'h00, 8'hFF, 8'h00);
    check("R5 inactive literal", rawStatus, 8'h00);
    // R6: enable gating
    step("R6 set bit3 level high", 8'h0B, 8'h00, 8'h08, 8'h00, 8'h08, 8'h00, 8'h00);
    check("R6 masked off", maskedStatus, 8'h00);
    check("R6 irq off", {7'b0, irqOut}, 8'h00);
    step("R6 enable on", 8'h0B, 8'h00, 8'h08, 8'h00, 8'h08, 8'h08, 8'h00);
    check("R6 irq on", {7'b0, irqOut}, 8'h01);

    // sweep against the model
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] clr;
      lfsrA = {lfsrA[14:0], lfsrA[15] ^ lfsrA[13] ^ lfsrA[12] ^ lfsrA[10]};
      if (n % 16 == 0)
        lfsrB = {lfsrB[14:0], lfsrB[15] ^ lfsrB[13] ^ lfsrB[12] ^ lfsrB[10]};
      clr = (n % 5 == 0) ? (lfsrA[15:8] & lfsrB[7:0]) : 8'h00;
      step("R2/R3/R4/R5/R7/R9 sweep", lfsrA[7:0] ^ lfsrA[15:8],
           lfsrB[7:0] & lfsrB[15:8], lfsrB[15:8], lfsrB[11:4],
           lfsrB[7:0] ^ lfsrB[12:5], lfsrB[9:2], clr);
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule